// File: doc/BRIEF.md
# UART Transmit/Receive Gating Controller

This block sits between the control bits of a UART and its serial shifters. It decides, one character at a time, whether a received character is written into the receive FIFO and whether the transmitter may start the next character. Requests to switch off the receiver or the transmitter, and blocking by the DSR input, are honoured only at character boundaries, so a character is never cut in half. In-band flow-control characters keep moving even when a path is switched off.

The receive side runs the state machine `RX_WAIT` / `RX_FRAME`. The transition `RX_WAIT -> RX_FRAME` is taken on `rx_start`. The transition `RX_FRAME -> RX_WAIT` is taken on `rx_done`. The receiver-off setting in force for a character is latched while in `RX_WAIT`, so it is fixed at the start edge. The transmit side runs `TX_IDLE` / `TX_DATA` / `TX_FLOW`. The transitions `TX_IDLE -> TX_FLOW` (a flow character is pending) and `TX_IDLE -> TX_DATA` (data may go) are taken only from idle. The transitions `TX_DATA -> TX_IDLE` and `TX_FLOW -> TX_IDLE` are taken on `tx_done`.

An 8-bit auxiliary status word reports the state of the block. Bit 0 is the receiver-off setting in force. Bit 1 is the transmitter-off setting in force. Bit 2 is DSR holding off data. Bit 3 is receive frame in progress. Bit 4 is the special-character flag, which is cleared on read. Bit 5 is reserved. Bit 6 is transmit character in progress. Bit 7 is transmitter idle.

Top module: `uart_path_gate`

## Requirements
- R1: The receiver-off setting used for a character is the value of `rx_off_req` at the `rx_start` edge. While a frame is in progress (status bit 3 = 1), status bit 0 does not change. A change to `rx_off_req` appears on status bit 0 one cycle after the frame ends.
- R2: When `rx_done` arrives while in `RX_FRAME`, `rx_store_en` is asserted in that same cycle exactly when the receiver-off setting in force is 0. A character received while the receiver is off is never stored.
- R3: `rx_flow_act` is asserted for a completed frame whenever `rx_is_flow` is 1, whether the receiver is on or off. `spc_det_en` is 0 while the receiver-off setting in force is 1. A special character received while the receiver is off does not set the flag.
- R4: The transmitter-off setting shown on status bit 1 only changes while in `TX_IDLE`. A change made during a character does not affect that character.
- R5: In `TX_IDLE`, a pending flow character (`tx_flow_pend` = 1) gets `tx_flow_go` even when the transmitter is off or DSR is blocking. A pending flow character takes priority over data. `tx_data_go` requires `tx_fifo_empty` = 0 and `tx_off_req` = 0.
- R6: When `dsr_fc_en` = 1 and `dsr_n` = 1, `tx_data_go` stays at 0 and status bit 2 reads 1. A character already started stays in progress (status bit 6 = 1) until `tx_done`, whatever DSR does.
- R7: Status bit 7 is 1 exactly when `tx_fifo_empty` and `tx_shift_empty` are both 1.
- R8: Status bit 4 is set in the cycle after a stored character with `rx_is_special` = 1. It clears in the cycle after a `stat_rd` pulse. If a set and a read fall in the same cycle, the bit stays 1.
- R9: Status bit 5 always reads 0.
- R10: After reset, both machines are idle, no go or store strobe is active, and the status word is 0x80 when both transmit empties are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_off_req | input | 1 | Receiver switch-off request |
| tx_off_req | input | 1 | Transmitter switch-off request |
| dsr_fc_en | input | 1 | Enables DSR-based transmit hold-off |
| dsr_n | input | 1 | DSR pin, active low (1 = inactive) |
| rx_start | input | 1 | Receive shifter found a start bit |
| rx_done | input | 1 | Receive shifter finished a character |
| rx_is_flow | input | 1 | Completed character is an in-band flow character |
| rx_is_special | input | 1 | Completed character matches the special character |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| tx_flow_pend | input | 1 | In-band flow character waiting to go out |
| tx_done | input | 1 | Transmit shifter finished a character |
| stat_rd | input | 1 | Status word read strobe |
| rx_store_en | output | 1 | Write the completed character into the receive FIFO |
| rx_flow_act | output | 1 | Act on the received flow character |
| spc_det_en | output | 1 | Special-character detection enabled |
| tx_data_go | output | 1 | Start a data character from the FIFO |
| tx_flow_go | output | 1 | Start the pending flow character |
| stat | output | 8 | Auxiliary status word |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a status read and the storing of a special character. The bench provokes this by raising `stat_rd` in the same cycle as an `rx_done` of a special character, and expects the flag still to be set one cycle later. The second pair is a pending flow character and data that is allowed to go, both present in one idle cycle. The bench sweeps every mix of transmitter-off, DSR enable, DSR level and flow pending, and expects only `tx_flow_go` whenever a flow character is pending.

// File: rtl/uart_gate_pkg.sv
`timescale 1ns/1ps
package uart_gate_pkg;
    typedef enum logic [0:0] {
        RX_WAIT  = 1'b0,
        RX_FRAME = 1'b1
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_FLOW = 2'd2
    } tx_state_t;

    localparam int STAT_W      = 8;
    localparam int ST_RX_OFF   = 0;
    localparam int ST_TX_OFF   = 1;
    localparam int ST_DSR_HOLD = 2;
    localparam int ST_RX_BUSY  = 3;
    localparam int ST_SPC      = 4;
    localparam int ST_RSVD     = 5;
    localparam int ST_TX_BUSY  = 6;
    localparam int ST_TX_IDLE  = 7;
endpackage

// File: rtl/rx_gate_fsm.sv
`timescale 1ns/1ps
module rx_gate_fsm
    import uart_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic off_req,
    input  logic start,
    input  logic done,
    input  logic is_flow,
    input  logic is_special,
    output logic store_en,
    output logic flow_act,
    output logic special_hit,
    output logic spc_det_en,
    output logic off_eff,
    output logic in_char
);
    rx_state_t state, nxt;
    logic      frame_end;

    // state register; the off setting is only sampled between characters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RX_WAIT;
            off_eff <= 1'b0;
        end else begin
            state <= nxt;
            if (state == RX_WAIT) off_eff <= off_req;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_WAIT:  if (start) nxt = RX_FRAME;
            RX_FRAME: if (done)  nxt = RX_WAIT;
            default:             nxt = RX_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        frame_end   = (state == RX_FRAME) && done;
        store_en    = frame_end && !off_eff;
        flow_act    = frame_end && is_flow;
        special_hit = store_en && is_special;
        spc_det_en  = !off_eff;
        in_char     = (state == RX_FRAME);
    end
endmodule

// File: rtl/tx_gate_fsm.sv
`timescale 1ns/1ps
module tx_gate_fsm
    import uart_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic off_req,
    input  logic dsr_fc_en,
    input  logic dsr_n,
    input  logic fifo_empty,
    input  logic flow_pend,
    input  logic done,
    output logic data_go,
    output logic flow_go,
    output logic off_eff,
    output logic dsr_hold,
    output logic in_char
);
    tx_state_t state, nxt;
    logic      data_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            off_eff <= 1'b0;
        end else begin
            state <= nxt;
            if (state == TX_IDLE) off_eff <= off_req;
        end
    end

    always_comb begin
        dsr_hold = dsr_fc_en && dsr_n;
        data_ok  = !fifo_empty && !off_req && !dsr_hold;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: begin
                if (flow_pend)    nxt = TX_FLOW;
                else if (data_ok) nxt = TX_DATA;
            end
            TX_DATA: if (done) nxt = TX_IDLE;
            TX_FLOW: if (done) nxt = TX_IDLE;
            default:           nxt = TX_IDLE;
        endcase
    end

    // outputs: permissions only leave the idle state
    always_comb begin
        flow_go = (state == TX_IDLE) && flow_pend;
        data_go = (state == TX_IDLE) && !flow_pend && data_ok;
        in_char = (state != TX_IDLE);
    end
endmodule

// File: rtl/aux_status_reg.sv
`timescale 1ns/1ps
module aux_status_reg
    import uart_gate_pkg::*;
#(
    parameter int W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  logic         special_hit,
    input  logic         rx_off,
    input  logic         tx_off,
    input  logic         dsr_hold,
    input  logic         rx_busy,
    input  logic         tx_busy,
    input  logic         fifo_empty,
    input  logic         shift_empty,
    output logic [W-1:0] stat
);
    logic spc_flag;

    // a new detection wins over a read in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           spc_flag <= 1'b0;
        else if (special_hit) spc_flag <= 1'b1;
        else if (rd)          spc_flag <= 1'b0;
    end

    always_comb begin
        stat              = '0;
        stat[ST_RX_OFF]   = rx_off;
        stat[ST_TX_OFF]   = tx_off;
        stat[ST_DSR_HOLD] = dsr_hold;
        stat[ST_RX_BUSY]  = rx_busy;
        stat[ST_SPC]      = spc_flag;
        stat[ST_RSVD]     = 1'b0;
        stat[ST_TX_BUSY]  = tx_busy;
        stat[ST_TX_IDLE]  = fifo_empty && shift_empty;
    end
endmodule

// File: rtl/uart_path_gate.sv
`timescale 1ns/1ps
module uart_path_gate
    import uart_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_off_req,
    input  logic              tx_off_req,
    input  logic              dsr_fc_en,
    input  logic              dsr_n,
    input  logic              rx_start,
    input  logic              rx_done,
    input  logic              rx_is_flow,
    input  logic              rx_is_special,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_empty,
    input  logic              tx_flow_pend,
    input  logic              tx_done,
    input  logic              stat_rd,
    output logic              rx_store_en,
    output logic              rx_flow_act,
    output logic              spc_det_en,
    output logic              tx_data_go,
    output logic              tx_flow_go,
    output logic [STAT_W-1:0] stat
);
    logic rx_off_eff, tx_off_eff, dsr_hold;
    logic rx_in_char, tx_in_char, special_hit;

    rx_gate_fsm u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_req    (rx_off_req),
        .start      (rx_start),
        .done       (rx_done),
        .is_flow    (rx_is_flow),
        .is_special (rx_is_special),
        .store_en   (rx_store_en),
        .flow_act   (rx_flow_act),
        .special_hit(special_hit),
        .spc_det_en (spc_det_en),
        .off_eff    (rx_off_eff),
        .in_char    (rx_in_char)
    );

    tx_gate_fsm u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .off_req   (tx_off_req),
        .dsr_fc_en (dsr_fc_en),
        .dsr_n     (dsr_n),
        .fifo_empty(tx_fifo_empty),
        .flow_pend (tx_flow_pend),
        .done      (tx_done),
        .data_go   (tx_data_go),
        .flow_go   (tx_flow_go),
        .off_eff   (tx_off_eff),
        .dsr_hold  (dsr_hold),
        .in_char   (tx_in_char)
    );

    aux_status_reg #(.W(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (stat_rd),
        .special_hit(special_hit),
        .rx_off     (rx_off_eff),
        .tx_off     (tx_off_eff),
        .dsr_hold   (dsr_hold),
        .rx_busy    (rx_in_char),
        .tx_busy    (tx_in_char),
        .fifo_empty (tx_fifo_empty),
        .shift_empty(tx_shift_empty),
        .stat       (stat)
    );
endmodule

// File: rtl/uart_path_gate_chk.sv
`timescale 1ns/1ps
module uart_path_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] stat,
    input logic       rx_store_en,
    input logic       rx_is_special,
    input logic       stat_rd,
    input logic       tx_data_go,
    input logic       tx_flow_go,
    input logic       tx_done,
    input logic       rx_in_char,
    input logic       tx_in_char
);
    assert_rx_off_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_in_char |=> $stable(stat[0]));

    assert_no_store_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store_en |-> !stat[0]);

    assert_tx_off_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_char |=> $stable(stat[1]));

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_data_go, tx_flow_go}));

    assert_char_not_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_char && !tx_done) |=> tx_in_char);

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store_en && rx_is_special) |=> stat[4]);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(rx_store_en && rx_is_special)) |=> !stat[4]);
endmodule

bind uart_path_gate uart_path_gate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat         (stat),
    .rx_store_en  (rx_store_en),
    .rx_is_special(rx_is_special),
    .stat_rd      (stat_rd),
    .tx_data_go   (tx_data_go),
    .tx_flow_go   (tx_flow_go),
    .tx_done      (tx_done),
    .rx_in_char   (rx_in_char),
    .tx_in_char   (tx_in_char)
);

// File: tb/uart_path_gate_bench.sv
`timescale 1ns/1ps
module uart_path_gate_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_off_req = 0, tx_off_req = 0, dsr_fc_en = 0, dsr_n = 0;
    logic rx_start = 0, rx_done = 0, rx_is_flow = 0, rx_is_special = 0;
    logic tx_fifo_empty = 1, tx_shift_empty = 1, tx_flow_pend = 0, tx_done = 0;
    logic stat_rd = 0;
    logic rx_store_en, rx_flow_act, spc_det_en, tx_data_go, tx_flow_go;
    logic [7:0] stat;
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_path_gate u_uart_path_gate (
        .clk(clk), .rst_n(rst_n), .rx_off_req(rx_off_req), .tx_off_req(tx_off_req),
        .dsr_fc_en(dsr_fc_en), .dsr_n(dsr_n), .rx_start(rx_start), .rx_done(rx_done),
        .rx_is_flow(rx_is_flow), .rx_is_special(rx_is_special),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
        .tx_flow_pend(tx_flow_pend), .tx_done(tx_done), .stat_rd(stat_rd),
        .rx_store_en(rx_store_en), .rx_flow_act(rx_flow_act), .spc_det_en(spc_det_en),
        .tx_data_go(tx_data_go), .tx_flow_go(tx_flow_go), .stat(stat)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic nstep();
        @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        nstep(); nstep();
        rst_n = 1'b1;
        nstep(); #1;
        // R10 reset state
        chk("R10 status", stat, 8'h80);
        chk("R10 strobes", {3'b0, rx_store_en, rx_flow_act, tx_data_go, tx_flow_go, 1'b0}, 8'h00);

        // receive sweep: off at start, off changed mid-frame, special, flow
        for (int i = 0; i < 16; i++) begin
            logic a, b, s, f;
            {a, b, s, f} = 4'(i);
            nstep(); rx_off_req = a;
            nstep(); rx_start = 1;
            nstep(); rx_start = 0; rx_off_req = b; #1;
            chk("R1 off latched at start", {7'b0, stat[0]}, {7'b0, a});
            chk("R1 frame busy", {7'b0, stat[3]}, 8'h01);
            nstep(); #1;
            chk("R1 off frozen in frame", {7'b0, stat[0]}, {7'b0, a});
            chk("R3 spc_det_en", {7'b0, spc_det_en}, {7'b0, !a});
            nstep(); rx_done = 1; rx_is_special = s; rx_is_flow = f; #1;
            chk("R2 store gate", {7'b0, rx_store_en}, {7'b0, !a});
            chk("R3 flow act", {7'b0, rx_flow_act}, {7'b0, f});
            nstep(); rx_done = 0; rx_is_special = 0; rx_is_flow = 0; #1;
            chk("R8 flag set", {7'b0, stat[4]}, {7'b0, (!a && s)});
            chk("R1 still old value", {7'b0, stat[0]}, {7'b0, a});
            chk("R9 reserved", {7'b0, stat[5]}, 8'h00);
            stat_rd = 1;
            nstep(); stat_rd = 0; #1;
            chk("R8 flag cleared", {7'b0, stat[4]}, 8'h00);
            chk("R1 new value applied", {7'b0, stat[0]}, {7'b0, b});
        end

        // R8 read and detection in the same cycle
        nstep(); rx_off_req = 0;
        nstep(); rx_start = 1;
        nstep(); rx_start = 0;
        nstep(); rx_done = 1; rx_is_special = 1; stat_rd = 1;
        nstep(); rx_done = 0; rx_is_special = 0; stat_rd = 0; #1;
        chk("R8 set wins over read", {7'b0, stat[4]}, 8'h01);
        stat_rd = 1;
        nstep(); stat_rd = 0; #1;
        chk("R8 read clears", {7'b0, stat[4]}, 8'h00);

        // transmit sweep: off, dsr enable, dsr level, flow pending
        for (int i = 0; i < 16; i++) begin
            logic o, e, n, p, dg, fg;
            {o, e, n, p} = 4'(i);
            dg = !p && !o && !(e && n);
            fg = p;
            nstep(); tx_off_req = o; dsr_fc_en = e; dsr_n = n;
            tx_fifo_empty = 1; tx_flow_pend = 0; tx_shift_empty = 1;
            nstep(); #1;
            chk("R4 off shown in idle", {7'b0, stat[1]}, {7'b0, o});
            chk("R6 dsr hold bit", {7'b0, stat[2]}, {7'b0, (e && n)});
            tx_fifo_empty = 0; tx_flow_pend = p; #1;
            chk("R5 data go", {7'b0, tx_data_go}, {7'b0, dg});
            chk("R5 flow go", {7'b0, tx_flow_go}, {7'b0, fg});
            if (dg || fg) begin
                nstep();
                tx_fifo_empty = 1; tx_flow_pend = 0; tx_shift_empty = 0;
                tx_off_req = !o; dsr_fc_en = 1; dsr_n = 1; #1;
                chk("R6 char in progress", {7'b0, stat[6]}, 8'h01);
                chk("R4 off frozen", {7'b0, stat[1]}, {7'b0, o});
                chk("R5 no second grant", {6'b0, tx_data_go, tx_flow_go}, 8'h00);
                nstep(); #1;
                chk("R6 not truncated", {7'b0, stat[6]}, 8'h01);
                tx_done = 1;
                nstep(); tx_done = 0; tx_shift_empty = 1; #1;
                chk("R6 char ended", {7'b0, stat[6]}, 8'h00);
                chk("R4 off held to boundary", {7'b0, stat[1]}, {7'b0, o});
            end else begin
                nstep(); tx_fifo_empty = 1; #1;
                chk("R6 nothing started", {7'b0, stat[6]}, 8'h00);
            end
        end

        // R7 idle bit over all empty combinations
        for (int i = 0; i < 4; i++) begin
            nstep(); tx_fifo_empty = i[0]; tx_shift_empty = i[1];
            tx_off_req = 1; #1;
            chk("R7 tx idle", {7'b0, stat[7]}, {7'b0, (i[0] && i[1])});
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule